// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block is the control side of operand bypassing for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory access, writeback. Each cycle it takes the register fields of the instruction in decode: two source numbers with their in-use flags, a destination number, a write enable, a load flag and a valid bit. It keeps its own shadow copy of those fields as the instruction moves through execute, memory and writeback. No data values enter the block.

From that shadow state it drives one mux select for each of the two ALU operands of the instruction in execute. A select picks the register file value, the execute/memory pipeline register or the memory/writeback pipeline register. The register file is assumed to write early in a cycle and read late in it, so a producer three or more slots ahead needs no bypass. A load result cannot reach the instruction directly behind it in time. In that case the block raises a hold for the PC and the fetch/decode register, and a bubble request for execute, for exactly one cycle. The bubble it places in its own shadow execute stage carries no write enable.

Top module: `hz_fwd_unit`

## Requirements
- R1: While reset is applied and after it is released, with no valid instruction issued, both selects read 0 (register file) and hold and bubble are low.
- R2: Select encoding is 0 = register file, 1 = execute/memory register, 2 = memory/writeback register. When the instruction one slot ahead of the one in execute writes a register that an in-use source reads, that operand's select is 1.
- R3: When the producer is two slots ahead, the select is 2.
- R4: When the producer is three or more slots ahead, the select is 0.
- R5: When the producers one and two slots ahead both write the register a source reads, the select is 1.
- R6: Register 0 never causes a bypass or a stall, whatever the producer's write enable or load flag.
- R7: A producer whose write enable is low, or whose valid bit is low, causes no bypass.
- R8: A load directly followed by an instruction that reads its destination raises hold and bubble together for exactly one cycle. The held instruction then sees select 2 for that operand. No load result is ever taken from the execute/memory register.
- R9: A source whose in-use flag is low matches nothing: it raises no stall and gets select 0.
- R10: A load two slots ahead of a reader causes no stall, and the reader's operand gets select 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | REG_W | First source register number in decode |
| id_rt | input | REG_W | Second source register number in decode |
| id_rs_used | input | 1 | First source is read |
| id_rt_used | input | 1 | Second source is read |
| id_rd | input | REG_W | Destination register number in decode |
| id_wen | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a load |
| fwd_a_sel | output | 2 | Operand A select for the instruction in execute |
| fwd_b_sel | output | 2 | Operand B select for the instruction in execute |
| hold_fd | output | 1 | Hold PC and fetch/decode register this cycle |
| bubble_ex | output | 1 | Place a bubble into execute at the next edge |

## Verification
The hardest state to reach is the cycle right after a load-use stall. The dependent instruction is still in decode, a bubble sits in execute and the load has moved to memory. The block must stay silent for that cycle and then bypass from memory/writeback. The bench reaches it by issuing a load and its reader back to back and presenting the reader again while hold is high, as fetch would. A scoreboard advances its own pipeline copy at every edge and compares all four outputs each cycle. The priority case is reached by two back-to-back writers of the same register ahead of one reader.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/hz_stage_track.sv
module hz_stage_track #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic [REG_W-1:0] id_rd,
  input  logic             id_wen,
  input  logic             id_load,
  output logic             ex_valid,
  output logic             ex_wen,
  output logic             ex_load,
  output logic [REG_W-1:0] ex_rd,
  output logic [REG_W-1:0] ex_rs,
  output logic [REG_W-1:0] ex_rt,
  output logic             ex_rs_used,
  output logic             ex_rt_used,
  output logic             mem_valid,
  output logic             mem_wen,
  output logic             mem_load,
  output logic [REG_W-1:0] mem_rd,
  output logic             wb_valid,
  output logic             wb_wen,
  output logic [REG_W-1:0] wb_rd
);
  logic             ex_valid_n, ex_wen_n, ex_load_n, ex_rs_used_n, ex_rt_used_n;
  logic [REG_W-1:0] ex_rd_n, ex_rs_n, ex_rt_n;
  logic             take_id;

  // An instruction enters execute only if decode holds one and no stall.
  assign take_id = id_valid && !stall;

  always_comb begin
    ex_valid_n   = 1'b0;
    ex_wen_n     = 1'b0;
    ex_load_n    = 1'b0;
    ex_rs_used_n = 1'b0;
    ex_rt_used_n = 1'b0;
    ex_rd_n      = '0;
    ex_rs_n      = '0;
    ex_rt_n      = '0;
    if (take_id) begin
      ex_valid_n   = 1'b1;
      ex_wen_n     = id_wen;
      ex_load_n    = id_load;
      ex_rs_used_n = id_rs_used;
      ex_rt_used_n = id_rt_used;
      ex_rd_n      = id_rd;
      ex_rs_n      = id_rs;
      ex_rt_n      = id_rt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid   <= 1'b0;
      ex_wen     <= 1'b0;
      ex_load    <= 1'b0;
      ex_rs_used <= 1'b0;
      ex_rt_used <= 1'b0;
      ex_rd      <= '0;
      ex_rs      <= '0;
      ex_rt      <= '0;
      mem_valid  <= 1'b0;
      mem_wen    <= 1'b0;
      mem_load   <= 1'b0;
      mem_rd     <= '0;
      wb_valid   <= 1'b0;
      wb_wen     <= 1'b0;
      wb_rd      <= '0;
    end else begin
      ex_valid   <= ex_valid_n;
      ex_wen     <= ex_wen_n;
      ex_load    <= ex_load_n;
      ex_rs_used <= ex_rs_used_n;
      ex_rt_used <= ex_rt_used_n;
      ex_rd      <= ex_rd_n;
      ex_rs      <= ex_rs_n;
      ex_rt      <= ex_rt_n;
      mem_valid  <= ex_valid;
      mem_wen    <= ex_wen;
      mem_load   <= ex_load;
      mem_rd     <= ex_rd;
      wb_valid   <= mem_valid;
      wb_wen     <= mem_wen;
      wb_rd      <= mem_rd;
    end
  end
endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic                       id_valid,
  input  logic [NSRC-1:0][REG_W-1:0] id_src,
  input  logic [NSRC-1:0]            id_src_used,
  input  logic                       ex_valid,
  input  logic                       ex_wen,
  input  logic                       ex_load,
  input  logic [REG_W-1:0]           ex_rd,
  output logic                       stall
);
  logic [NSRC-1:0] hit;
  logic            producer_ok;

  assign producer_ok = ex_valid && ex_wen && ex_load && (ex_rd != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = id_src_used[s] && (id_src[s] == ex_rd);
  end

  assign stall = id_valid && producer_ok && (|hit);
endmodule

// File: rtl/hz_fwd_select.sv
module hz_fwd_select #(
  parameter int REG_W = 5
) (
  input  logic             src_used,
  input  logic [REG_W-1:0] src,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_valid,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_rd,
  output logic [1:0]       sel
);
  import hz_pkg::*;

  logic     live, hit_mem, hit_wb;
  fwd_sel_e sel_e;

  assign live    = src_used && (src != '0);
  assign hit_mem = live && mem_valid && mem_wen && (mem_rd == src);
  assign hit_wb  = live && wb_valid  && wb_wen  && (wb_rd  == src);

  always_comb begin
    if (hit_mem)     sel_e = FWD_EXMEM;
    else if (hit_wb) sel_e = FWD_MEMWB;
    else             sel_e = FWD_RF;
  end

  assign sel = sel_e;
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic [REG_W-1:0] id_rd,
  input  logic             id_wen,
  input  logic             id_load,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             hold_fd,
  output logic             bubble_ex
);
  localparam int NSRC = 2;

  logic             rst_s_n;
  logic             stall;
  logic             ex_valid, ex_wen, ex_load, ex_rs_used, ex_rt_used;
  logic [REG_W-1:0] ex_rd, ex_rs, ex_rt;
  logic             mem_valid, mem_wen, mem_load;
  logic [REG_W-1:0] mem_rd;
  logic             wb_valid, wb_wen;
  logic [REG_W-1:0] wb_rd;

  logic [NSRC-1:0][REG_W-1:0] id_src, ex_src;
  logic [NSRC-1:0]            id_src_used, ex_src_used;
  logic [NSRC-1:0][1:0]       sel_v;

  assign id_src      = {id_rt, id_rs};
  assign id_src_used = {id_rt_used, id_rs_used};
  assign ex_src      = {ex_rt, ex_rs};
  assign ex_src_used = {ex_rt_used, ex_rs_used};

  hz_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  hz_stage_track #(.REG_W(REG_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .stall      (stall),
    .id_valid   (id_valid),
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .id_rs_used (id_rs_used),
    .id_rt_used (id_rt_used),
    .id_rd      (id_rd),
    .id_wen     (id_wen),
    .id_load    (id_load),
    .ex_valid   (ex_valid),
    .ex_wen     (ex_wen),
    .ex_load    (ex_load),
    .ex_rd      (ex_rd),
    .ex_rs      (ex_rs),
    .ex_rt      (ex_rt),
    .ex_rs_used (ex_rs_used),
    .ex_rt_used (ex_rt_used),
    .mem_valid  (mem_valid),
    .mem_wen    (mem_wen),
    .mem_load   (mem_load),
    .mem_rd     (mem_rd),
    .wb_valid   (wb_valid),
    .wb_wen     (wb_wen),
    .wb_rd      (wb_rd)
  );

  hz_loaduse_detect #(.REG_W(REG_W), .NSRC(NSRC)) u_lu (
    .id_valid    (id_valid),
    .id_src      (id_src),
    .id_src_used (id_src_used),
    .ex_valid    (ex_valid),
    .ex_wen      (ex_wen),
    .ex_load     (ex_load),
    .ex_rd       (ex_rd),
    .stall       (stall)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    hz_fwd_select #(.REG_W(REG_W)) u_sel (
      .src_used  (ex_src_used[s]),
      .src       (ex_src[s]),
      .mem_valid (mem_valid),
      .mem_wen   (mem_wen),
      .mem_rd    (mem_rd),
      .wb_valid  (wb_valid),
      .wb_wen    (wb_wen),
      .wb_rd     (wb_rd),
      .sel       (sel_v[s])
    );
  end

  assign fwd_a_sel = sel_v[0];
  assign fwd_b_sel = sel_v[1];
  assign hold_fd   = stall;
  assign bubble_ex = stall;
endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       fwd_a_sel,
  input logic [1:0]       fwd_b_sel,
  input logic             hold_fd,
  input logic             id_rs_used,
  input logic             id_rt_used,
  input logic [REG_W-1:0] ex_rs,
  input logic [REG_W-1:0] ex_rt,
  input logic             mem_valid,
  input logic             mem_wen,
  input logic             mem_load,
  input logic             wb_valid,
  input logic             wb_wen
);
  assert_sel_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

  assert_zero_reg_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs == '0) |-> (fwd_a_sel == 2'b00));

  assert_zero_reg_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rt == '0) |-> (fwd_b_sel == 2'b00));

  assert_exmem_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_a_sel == 2'b01) || (fwd_b_sel == 2'b01)) |-> (mem_valid && mem_wen));

  assert_memwb_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_a_sel == 2'b10) || (fwd_b_sel == 2'b10)) |-> (wb_valid && wb_wen));

  assert_single_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fd |=> !hold_fd);

  assert_no_load_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_a_sel == 2'b01) || (fwd_b_sel == 2'b01)) |-> !mem_load);

  assert_unused_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_rs_used && !id_rt_used) |-> !hold_fd);
endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .fwd_a_sel  (fwd_a_sel),
  .fwd_b_sel  (fwd_b_sel),
  .hold_fd    (hold_fd),
  .id_rs_used (id_rs_used),
  .id_rt_used (id_rt_used),
  .ex_rs      (ex_rs),
  .ex_rt      (ex_rt),
  .mem_valid  (mem_valid),
  .mem_wen    (mem_wen),
  .mem_load   (mem_load),
  .wb_valid   (wb_valid),
  .wb_wen     (wb_wen)
);

// File: tb/hz_fwd_unit_bench.sv
module hz_fwd_unit_bench;
  localparam int RW = 5;

  typedef struct packed {
    logic          v;
    logic          w;
    logic          l;
    logic [RW-1:0] rd;
    logic [RW-1:0] rs;
    logic [RW-1:0] rt;
    logic          su;
    logic          tu;
  } ins_t;

  logic          clk;
  logic          rst_n;
  logic          id_valid, id_rs_used, id_rt_used, id_wen, id_load;
  logic [RW-1:0] id_rs, id_rt, id_rd;
  logic [1:0]    fwd_a_sel, fwd_b_sel;
  logic          hold_fd, bubble_ex;

  int total = 0;
  int bad   = 0;

  ins_t m_ex, m_mem, m_wb, cur_id;
  logic cur_stall;

  hz_fwd_unit #(.REG_W(RW)) u_hz_fwd_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_valid   (id_valid),
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .id_rs_used (id_rs_used),
    .id_rt_used (id_rt_used),
    .id_rd      (id_rd),
    .id_wen     (id_wen),
    .id_load    (id_load),
    .fwd_a_sel  (fwd_a_sel),
    .fwd_b_sel  (fwd_b_sel),
    .hold_fd    (hold_fd),
    .bubble_ex  (bubble_ex)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic ins_t mk(logic v, logic w, logic l, int rd, int rs, int rt,
                              logic su, logic tu);
    ins_t i;
    i.v = v; i.w = w; i.l = l;
    i.rd = RW'(rd); i.rs = RW'(rs); i.rt = RW'(rt);
    i.su = su; i.tu = tu;
    return i;
  endfunction

  function automatic ins_t alu(int rd, int rs, int rt);
    return mk(1'b1, 1'b1, 1'b0, rd, rs, rt, 1'b1, 1'b1);
  endfunction

  function automatic ins_t ld(int rd, int rs);
    return mk(1'b1, 1'b1, 1'b1, rd, rs, 0, 1'b1, 1'b0);
  endfunction

  function automatic ins_t nop();
    return mk(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0);
  endfunction

  function automatic ins_t filler();
    return alu(30, 31, 31);
  endfunction

  // Scoreboard select from the requirement rules (priority, r0, qualifiers).
  function automatic logic [1:0] ref_sel(logic used, logic [RW-1:0] r);
    if (!used || r == '0) return 2'd0;
    if (m_mem.v && m_mem.w && m_mem.rd == r) return 2'd1;
    if (m_wb.v && m_wb.w && m_wb.rd == r) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic ref_stall(ins_t i);
    if (!i.v || !m_ex.v || !m_ex.w || !m_ex.l || m_ex.rd == '0) return 1'b0;
    return (i.su && i.rs == m_ex.rd) || (i.tu && i.rt == m_ex.rd);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(ins_t i);
    id_valid   = i.v;
    id_wen     = i.w;
    id_load    = i.l;
    id_rd      = i.rd;
    id_rs      = i.rs;
    id_rt      = i.rt;
    id_rs_used = i.su;
    id_rt_used = i.tu;
  endtask

  // One cycle: advance scoreboard past the edge, present i, compare outputs.
  task automatic step(ins_t i, string tag);
    logic es;
    @(posedge clk);
    #1;
    m_wb  = m_mem;
    m_mem = m_ex;
    m_ex  = (cur_stall || !cur_id.v) ? nop() : cur_id;
    @(negedge clk);
    drive(i);
    cur_id = i;
    #2;
    es = ref_stall(i);
    cur_stall = es;
    chk(tag, "hold_fd", int'(hold_fd), int'(es));
    chk(tag, "bubble_ex", int'(bubble_ex), int'(es));
    chk(tag, "fwd_a_sel", int'(fwd_a_sel), int'(ref_sel(m_ex.su, m_ex.rs)));
    chk(tag, "fwd_b_sel", int'(fwd_b_sel), int'(ref_sel(m_ex.tu, m_ex.rt)));
  endtask

  // Issue as fetch would: re-present while the hold is high.
  task automatic issue(ins_t i, string tag);
    step(i, tag);
    while (cur_stall) step(i, tag);
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) step(nop(), "drain");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(nop());
    cur_id = nop(); cur_stall = 1'b0;
    m_ex = nop(); m_mem = nop(); m_wb = nop();
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "hold_in_reset", int'(hold_fd), 0);
    chk("R1", "a_sel_in_reset", int'(fwd_a_sel), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "hold_after", int'(hold_fd), 0);
    chk("R1", "bubble_after", int'(bubble_ex), 0);
    chk("R1", "a_sel_after", int'(fwd_a_sel), 0);
    chk("R1", "b_sel_after", int'(fwd_b_sel), 0);
  endtask

  task automatic t_dist1();
    issue(alu(5, 1, 2), "R2");
    issue(alu(12, 5, 3), "R2");
    step(nop(), "R2");
    chk("R2", "a_sel_dist1", int'(fwd_a_sel), 1);
    chk("R2", "b_sel_dist1", int'(fwd_b_sel), 0);
    drain();
  endtask

  task automatic t_dist2();
    issue(alu(7, 1, 2), "R3");
    issue(filler(), "R3");
    issue(alu(13, 3, 7), "R3");
    step(nop(), "R3");
    chk("R3", "b_sel_dist2", int'(fwd_b_sel), 2);
    chk("R3", "a_sel_dist2", int'(fwd_a_sel), 0);
    drain();
  endtask

  task automatic t_dist3();
    issue(alu(9, 1, 2), "R4");
    issue(filler(), "R4");
    issue(filler(), "R4");
    issue(alu(14, 9, 9), "R4");
    step(nop(), "R4");
    chk("R4", "a_sel_dist3", int'(fwd_a_sel), 0);
    chk("R4", "b_sel_dist3", int'(fwd_b_sel), 0);
    issue(alu(9, 1, 2), "R4");
    for (int k = 0; k < 4; k++) issue(filler(), "R4");
    issue(alu(14, 9, 1), "R4");
    step(nop(), "R4");
    chk("R4", "a_sel_dist5", int'(fwd_a_sel), 0);
    drain();
  endtask

  task automatic t_prio();
    issue(alu(4, 1, 2), "R5");
    issue(alu(4, 3, 2), "R5");
    issue(alu(15, 4, 4), "R5");
    step(nop(), "R5");
    chk("R5", "a_sel_both", int'(fwd_a_sel), 1);
    chk("R5", "b_sel_both", int'(fwd_b_sel), 1);
    drain();
  endtask

  task automatic t_r0();
    issue(alu(0, 1, 2), "R6");
    issue(alu(16, 0, 0), "R6");
    step(nop(), "R6");
    chk("R6", "a_sel_r0", int'(fwd_a_sel), 0);
    chk("R6", "b_sel_r0", int'(fwd_b_sel), 0);
    drain();
    issue(ld(0, 1), "R6");
    step(alu(16, 0, 2), "R6");
    chk("R6", "hold_r0_load", int'(hold_fd), 0);
    drain();
  endtask

  task automatic t_qual();
    issue(mk(1'b1, 1'b0, 1'b0, 6, 1, 2, 1'b1, 1'b1), "R7");
    issue(alu(17, 6, 6), "R7");
    step(nop(), "R7");
    chk("R7", "a_sel_wen0", int'(fwd_a_sel), 0);
    drain();
    issue(mk(1'b0, 1'b1, 1'b0, 6, 1, 2, 1'b1, 1'b1), "R7");
    issue(alu(17, 6, 3), "R7");
    step(nop(), "R7");
    chk("R7", "a_sel_invalid", int'(fwd_a_sel), 0);
    drain();
  endtask

  task automatic t_loaduse();
    issue(ld(8, 1), "R8");
    step(alu(18, 8, 3), "R8");
    chk("R8", "hold_first", int'(hold_fd), 1);
    chk("R8", "bubble_first", int'(bubble_ex), 1);
    step(alu(18, 8, 3), "R8");
    chk("R8", "hold_second", int'(hold_fd), 0);
    step(nop(), "R8");
    chk("R8", "a_sel_after_stall", int'(fwd_a_sel), 2);
    drain();
    issue(ld(11, 1), "R8");
    step(alu(19, 2, 11), "R8");
    chk("R8", "hold_rt", int'(hold_fd), 1);
    step(alu(19, 2, 11), "R8");
    step(nop(), "R8");
    chk("R8", "b_sel_after_stall", int'(fwd_b_sel), 2);
    drain();
  endtask

  task automatic t_unused();
    issue(ld(10, 1), "R9");
    step(mk(1'b1, 1'b1, 1'b0, 20, 10, 10, 1'b0, 1'b0), "R9");
    chk("R9", "hold_unused", int'(hold_fd), 0);
    step(nop(), "R9");
    chk("R9", "a_sel_unused", int'(fwd_a_sel), 0);
    chk("R9", "b_sel_unused", int'(fwd_b_sel), 0);
    drain();
  endtask

  task automatic t_load_d2();
    issue(ld(11, 1), "R10");
    issue(filler(), "R10");
    step(alu(21, 2, 11), "R10");
    chk("R10", "hold_load_d2", int'(hold_fd), 0);
    step(nop(), "R10");
    chk("R10", "b_sel_load_d2", int'(fwd_b_sel), 2);
    drain();
  endtask

  initial begin
    #(10 * 50000);
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_dist1();
    t_dist2();
    t_dist3();
    t_prio();
    t_r0();
    t_qual();
    t_loaduse();
    t_unused();
    t_load_d2();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule